// File: doc/BRIEF.md
# Round-Based Fault-Tolerant Clock Synchronizer

This block keeps a local tick counter that measures the position inside the current synchronization round. Once per round it takes part in an agreement exchange. Each peer source delivers round markers as one-cycle pulses. Every pulse carries a round number and a flag that marks the message as manifestly bad. The block records at most one valid marker per source for the round it is waiting on. When the number of distinct sources recorded reaches a fixed hybrid-majority threshold, the block accepts the round. Accepting the round realigns the counter to the start of the next round and advances the round index.

The same logic serves both ends of the exchange, selected by a role input. In the redundancy-manager role, the block broadcasts its own marker when its counter reaches the ready point. The ready point lies a fixed offset before the nominal round length, and the offset covers transport delay. In the bus-interface role, the block does not announce readiness itself. Instead it echoes every accept as a broadcast pulse, which relays the agreed round onward and aligns the interface units to the managers.

If no accept arrives within a fixed window after the ready point, a sticky fault flag is raised. The next accept clears it. The round length, the ready offset, the source count, the threshold, the fault window and the round-number width are all compile-time parameters.

Top module: `rndsync_top`

## Requirements
- R1: After reset, `count_o` increases by exactly one on every clock edge that does not follow an accept cycle. It holds at its all-ones value instead of wrapping.
- R2: With `role_biu_i` = 0, `bcast_o` is high for exactly one cycle, the cycle in which `count_o` equals ROUND_LEN − READY_OFS (28 with the defaults). It is low in every other cycle.
- R3: Source i's round number is `mark_rnd_i[i*RND_W +: RND_W]`. That source is recorded at a clock edge where `mark_vld_i[i]`=1, `mark_bad_i[i]`=0 and its round number equals `round_o`. Repeated markers from one source count once. `accept_o` is high in exactly those cycles in which the number of recorded sources is at least THRESH (3 with the defaults).
- R4: A marker that has `mark_bad_i` set is never recorded.
- R5: A marker whose round number differs from `round_o` is never recorded.
- R6: In the cycle after an accept cycle, `count_o` is 0 and `round_o` is its previous value plus one, modulo 2^RND_W. All records are cleared at that edge. Markers presented during the accept cycle are discarded.
- R7: With `role_biu_i` = 1, `bcast_o` equals `accept_o` in every cycle. It does not pulse at the ready point, and the counter realigns on accept exactly as in R6.
- R8: `sync_fault_o` becomes 1 at the edge where `count_o` equals ROUND_LEN − READY_OFS + FAULT_WIN (44 with the defaults) and the current cycle is not an accept cycle. It stays 1 until the edge that ends the next accept cycle.
- R9: During and right after a synchronous reset, `count_o`=0, `round_o`=0, `accept_o`=0, `bcast_o`=0, `sync_fault_o`=0, and no source is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator tick clock |
| rst | input | 1 | Synchronous active-high reset |
| role_biu_i | input | 1 | 0 = redundancy-manager role, 1 = bus-interface role |
| mark_vld_i | input | N_SRC | Per-source round-marker pulse |
| mark_bad_i | input | N_SRC | Per-source manifestly-bad flag |
| mark_rnd_i | input | N_SRC*RND_W | Per-source marker round number, source i at bits i*RND_W upward |
| bcast_o | output | 1 | Outgoing marker pulse (ready or echoed accept) |
| accept_o | output | 1 | Round accepted this cycle |
| count_o | output | CNT_W | Tick count within the round |
| round_o | output | RND_W | Round index being waited on |
| sync_fault_o | output | 1 | Accept overdue after the ready point |

## Verification
The directed patterns each isolate one kind of vote. One pattern mixes bad and good markers so that only the good ones fall short of the threshold. One sends enough markers with the wrong round number. One repeats a single source to show that duplicates do not add votes. One presents markers in the accept cycle itself to show that they are dropped. A silent stretch past the fault window separates the fault flag from the accept path. A role switch shows that the broadcast follows the ready point in one role and the accept in the other. Seeded random marker traffic mixes current, stale and future round numbers with random bad flags in both roles. A bench-side model predicts every output in every cycle, which exposes slips in counting, clearing or round matching that the directed cases do not reach.

// File: rtl/rndsync_pkg.sv
package rndsync_pkg;

    typedef enum logic {
        ROLE_RMU = 1'b0,
        ROLE_BIU = 1'b1
    } role_e;

    typedef struct packed {
        logic ready;
        logic fault;
    } tmr_evt_t;

    function automatic int unsigned ones32(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/rndsync_timer.sv
module rndsync_timer #(
    parameter int unsigned ROUND_LEN = 32,
    parameter int unsigned READY_OFS = 4,
    parameter int unsigned FAULT_WIN = 16,
    parameter int unsigned CNT_W     = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    output logic [CNT_W-1:0]      cnt_o,
    output rndsync_pkg::tmr_evt_t evt_o
);
    localparam logic [CNT_W-1:0] READY_PT = CNT_W'(ROUND_LEN - READY_OFS);
    localparam logic [CNT_W-1:0] FAULT_PT = CNT_W'(ROUND_LEN - READY_OFS + FAULT_WIN);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            if (load_i) begin
                cnt_q <= '0;
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (load_i) begin
                fault_q <= 1'b0;
            end else if (cnt_q == FAULT_PT) begin
                fault_q <= 1'b1;
            end
        end
    end

    assign cnt_o       = cnt_q;
    assign evt_o.ready = (cnt_q == READY_PT);
    assign evt_o.fault = fault_q;

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R6
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> cnt_q == '0);

    // R8
    fault_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_q) |-> cnt_q == FAULT_PT + 1'b1);

endmodule

// File: rtl/rndsync_tally.sv
module rndsync_tally #(
    parameter int unsigned N_SRC  = 4,
    parameter int unsigned RND_W  = 4,
    parameter int unsigned THRESH = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_SRC-1:0]       vld_i,
    input  logic [N_SRC-1:0]       bad_i,
    input  logic [N_SRC*RND_W-1:0] rnd_i,
    input  logic [RND_W-1:0]       cur_i,
    output logic                   acc_o
);
    logic [N_SRC-1:0] hit;
    logic [N_SRC-1:0] seen_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = vld_i[i] & ~bad_i[i] & (rnd_i[i*RND_W +: RND_W] == cur_i);
    end

    assign acc_o = (rndsync_pkg::ones32(32'(seen_q)) >= THRESH);

    always_ff @(posedge clk) begin
        if (rst || acc_o) begin
            seen_q <= '0;
        end else begin
            seen_q <= seen_q | hit;
        end
    end

    // R3
    latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_o |=> (($past(seen_q) & ~seen_q) == '0));

    // R6
    latch_clr_chk: assert property (@(posedge clk) disable iff (rst)
        acc_o |=> seen_q == '0);

    // R4
    bad_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc_o && (vld_i & ~bad_i) == '0) |=> $stable(seen_q));

endmodule

// File: rtl/rndsync_top.sv
module rndsync_top #(
    parameter int unsigned N_SRC     = 4,
    parameter int unsigned ROUND_LEN = 32,
    parameter int unsigned READY_OFS = 4,
    parameter int unsigned THRESH    = 3,
    parameter int unsigned FAULT_WIN = 16,
    parameter int unsigned RND_W     = 4,
    localparam int unsigned CNT_W    = $clog2(ROUND_LEN + FAULT_WIN + 2)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   role_biu_i,
    input  logic [N_SRC-1:0]       mark_vld_i,
    input  logic [N_SRC-1:0]       mark_bad_i,
    input  logic [N_SRC*RND_W-1:0] mark_rnd_i,
    output logic                   bcast_o,
    output logic                   accept_o,
    output logic [CNT_W-1:0]       count_o,
    output logic [RND_W-1:0]       round_o,
    output logic                   sync_fault_o
);
    import rndsync_pkg::*;

    role_e            role;
    tmr_evt_t         evt;
    logic             acc;
    logic [RND_W-1:0] round_q;

    assign role = role_e'(role_biu_i);

    rndsync_tally #(
        .N_SRC (N_SRC),
        .RND_W (RND_W),
        .THRESH(THRESH)
    ) tally_i (
        .clk  (clk),
        .rst  (rst),
        .vld_i(mark_vld_i),
        .bad_i(mark_bad_i),
        .rnd_i(mark_rnd_i),
        .cur_i(round_q),
        .acc_o(acc)
    );

    rndsync_timer #(
        .ROUND_LEN(ROUND_LEN),
        .READY_OFS(READY_OFS),
        .FAULT_WIN(FAULT_WIN),
        .CNT_W    (CNT_W)
    ) timer_i (
        .clk   (clk),
        .rst   (rst),
        .load_i(acc),
        .cnt_o (count_o),
        .evt_o (evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            round_q <= '0;
        end else if (acc) begin
            round_q <= round_q + 1'b1;
        end
    end

    assign bcast_o      = (role == ROLE_BIU) ? acc : evt.ready;
    assign accept_o     = acc;
    assign round_o      = round_q;
    assign sync_fault_o = evt.fault;

    // R6
    round_adv_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> round_q == $past(round_q) + 1'b1);

    // R6
    round_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(round_q));

    // R2
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (role == ROLE_RMU && bcast_o && !acc) |=> !(role == ROLE_RMU && bcast_o));

endmodule

// File: tb/rndsync_top_tb_top.sv
`timescale 1ns/1ps
module rndsync_top_tb_top;
    localparam int N  = 4;
    localparam int RW = 4;
    localparam int TH = 3;
    localparam int RP = 28;
    localparam int FP = 44;
    localparam int CMAX = 63;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          role_biu = 1'b0;
    logic [N-1:0]  mvld = '0;
    logic [N-1:0]  mbad = '0;
    logic [N*RW-1:0] mrnd = '0;
    logic          bcast, accept, fault;
    logic [5:0]    count;
    logic [RW-1:0] rnd;

    int nchk = 0;
    int nfail = 0;

    int       m_cnt;
    int       m_rnd;
    logic [N-1:0] m_seen;
    bit       m_fault;

    always #2 clk = ~clk;

    rndsync_top dut_i (
        .clk(clk), .rst(rst), .role_biu_i(role_biu),
        .mark_vld_i(mvld), .mark_bad_i(mbad), .mark_rnd_i(mrnd),
        .bcast_o(bcast), .accept_o(accept), .count_o(count),
        .round_o(rnd), .sync_fault_o(fault)
    );

    function automatic int ones(input logic [N-1:0] v);
        int n = 0;
        for (int i = 0; i < N; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [N*RW-1:0] same_rnd(input int r);
        logic [N*RW-1:0] f;
        for (int i = 0; i < N; i++) f[i*RW +: RW] = RW'(r);
        return f;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int exp_acc;
        exp_acc = (ones(m_seen) >= TH) ? 1 : 0;
        chk("R1", int'(count), m_cnt);
        chk("R6", int'(rnd), m_rnd);
        chk("R3", int'(accept), exp_acc);
        if (role_biu) chk("R7", int'(bcast), exp_acc);
        else          chk("R2", int'(bcast), (m_cnt == RP) ? 1 : 0);
        chk("R8", int'(fault), int'(m_fault));
    endtask

    task automatic step(input logic [N-1:0] v, input logic [N-1:0] b, input logic [N*RW-1:0] r);
        bit acc;
        mvld = v; mbad = b; mrnd = r;
        @(posedge clk);
        acc = (ones(m_seen) >= TH);
        if (acc) begin
            m_seen  = '0;
            m_cnt   = 0;
            m_rnd   = (m_rnd + 1) % (1 << RW);
            m_fault = 1'b0;
        end else begin
            for (int i = 0; i < N; i++)
                if (v[i] && !b[i] && int'(r[i*RW +: RW]) == m_rnd) m_seen[i] = 1'b1;
            if (m_cnt == FP) m_fault = 1'b1;
            if (m_cnt != CMAX) m_cnt++;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, '0);
    endtask

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17C0DE));
        m_cnt = 0; m_rnd = 0; m_seen = '0; m_fault = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk("R9", int'(count), 0);
        chk("R9", int'(rnd), 0);
        chk("R9", int'(accept), 0);
        chk("R9", int'(bcast), 0);
        chk("R9", int'(fault), 0);
        rst = 1'b0;

        idle(5);
        // R4: two good, two bad -> below threshold
        step(4'b1111, 4'b0011, same_rnd(m_rnd));
        chk("R4", int'(accept), 0);
        step(4'b0001, 4'b0000, same_rnd(m_rnd));
        chk("R3", int'(accept), 1);
        // R6: markers presented in the accept cycle are discarded
        step(4'b1111, 4'b0000, same_rnd(m_rnd + 1));
        chk("R6", int'(count), 0);
        chk("R6", int'(rnd), 1);
        step('0, '0, '0);
        chk("R6", int'(accept), 0);

        // R5: wrong round number ignored
        step(4'b0111, 4'b0000, same_rnd(m_rnd + 1));
        chk("R5", int'(accept), 0);
        step(4'b0111, 4'b0000, same_rnd(m_rnd + 3));
        chk("R5", int'(accept), 0);
        // R3: duplicates from one source count once
        step(4'b1000, 4'b0000, same_rnd(m_rnd));
        step(4'b1000, 4'b0000, same_rnd(m_rnd));
        step(4'b1000, 4'b0000, same_rnd(m_rnd));
        chk("R3", int'(accept), 0);

        // R8: silence past the fault window, R2 ready pulse seen on the way
        idle(60);
        chk("R8", int'(fault), 1);
        chk("R1", int'(count), m_cnt);
        step(4'b0111, 4'b0000, same_rnd(m_rnd));
        chk("R3", int'(accept), 1);
        step('0, '0, '0);
        chk("R8", int'(fault), 0);

        // R7: interface role echoes accept, no pulse at ready point
        role_biu = 1'b1;
        idle(35);
        step(4'b1110, 4'b0000, same_rnd(m_rnd));
        chk("R7", int'(bcast), 1);
        step('0, '0, '0);
        chk("R7", int'(bcast), 0);
        chk("R7", int'(count), 0);

        // constrained random traffic in both roles
        for (int c = 0; c < 6000; c++) begin
            logic [N-1:0] v, b;
            logic [N*RW-1:0] r;
            if (c % 700 == 0) role_biu = ~role_biu;
            for (int i = 0; i < N; i++) begin
                int sel;
                v[i] = ($urandom % 10) == 0;
                b[i] = ($urandom % 4) == 0;
                sel  = $urandom % 10;
                if (sel < 7)      r[i*RW +: RW] = RW'(m_rnd);
                else if (sel < 9) r[i*RW +: RW] = RW'(m_rnd + 1);
                else              r[i*RW +: RW] = RW'($urandom);
            end
            step(v, b, r);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule